// File: doc/BRIEF.md
# Multi-Channel Threshold Watchdog Monitor

The monitor sits beside a converter that produces a stream of sample results. Each result comes with a 5-bit channel number and a 2-bit resolution code. The monitor aligns every result to the top of a 12-bit field. It then compares the aligned value against the window of each of its watchdogs. A watchdog that sees a sample from a channel it guards, lying outside its window, raises a sticky flag. The same flag drives a dedicated hardware line, which can feed a timer's external trigger. It also feeds a combined interrupt through a per-watchdog enable.

There are two ways a watchdog chooses its channels. The first watchdog guards no channel, all channels, or one chosen channel. Every further watchdog (two by default) guards any subset of channels through a one-bit-per-channel mask, and is switched off by an all-zero mask. Software programs the monitor through a small write/read register port. It clears flags by writing ones.

Top module: `thr_watchdog_monitor`

## Requirements
- R1: While bit 0 (enable) of the first watchdog's control word (address 0) is 0, no sample sets status flag 0.
- R2: With enable at 1 and bit 1 (single) at 0, the first watchdog guards every channel.
- R3: With enable and single both at 1, the first watchdog guards only the channel held in control bits [8:4]; samples from other channels leave flag 0 untouched.
- R4: Watchdog k (k = 1, 2) guards channel c exactly when bit c of its mask word (address 2k) is 1; an all-zero mask guards nothing.
- R5: A guarded sample sets the watchdog's flag when the aligned value is strictly below the low threshold (bits [11:0]) or strictly above the high threshold (bits [27:16]) of its threshold word (address 2k+1). A value equal to either threshold is inside the window.
- R6: Resolution code 0 compares the 12-bit sample as is. Codes 1, 2 and 3 take the low 10, 8 or 6 bits, shift them to the top of the 12-bit field and fill the bits below with zeros. The unused upper input bits are ignored.
- R7: Writing the status word (address 6) clears each flag whose bit [k] is written 1; bits written 0 leave their flags unchanged.
- R8: When an out-of-window guarded sample and a clearing write for the same flag fall in one cycle, the flag is 1 afterwards.
- R9: A set flag stays set until software clears it.
- R10: `irq` is 1 exactly when some flag k is set while bit k of the interrupt-enable word (address 7) is 1.
- R11: `wd_out[k]` rises in the cycle after the out-of-window sample and stays high until flag k is cleared. Bit k of the status word reads back the same flag.
- R12: After reset the control, mask, status and enable words read 0. Each threshold word reads low 0x000 and high 0xFFF. Unused bits and unused addresses read 0.
- R13: `reg_rdata` shows, in the same cycle, the word at `reg_addr`. A write takes effect from the next cycle. A sample in the write cycle is judged against the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample result is present this cycle |
| smp_chan | input | 5 | Channel number of the sample |
| smp_res | input | 2 | Resolution code: 0 = 12, 1 = 10, 2 = 8, 3 = 6 bits |
| smp_data | input | 12 | Right-aligned sample result |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | OR of enabled flags |
| wd_out | output | 3 | Per-watchdog out-of-window hardware line |

## Verification
Several rules are checked by assertions on every cycle: a flag only rises after an out-of-window sample, an in-window or unguarded sample never raises it, a raised flag persists without a clear, a set beats a clear, and a clear without a set drops it. Other behaviours need a model and show only in the bench's scenarios. These are the decoding of channel selection from register words, the left alignment at each resolution, the reset contents, readback, and the interrupt masking. A behavioural model checks those every clock across the directed cases and a long random mix of writes and samples.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
   // Resolution codes carried with each sample result
   typedef enum logic [1:0] {
      RES_FULL = 2'd0,
      RES_LESS2 = 2'd1,
      RES_LESS4 = 2'd2,
      RES_LESS6 = 2'd3
   } res_code_e;

   localparam int CTRL_EN_BIT     = 0;
   localparam int CTRL_SINGLE_BIT = 1;
   localparam int CTRL_CH_LSB     = 4;
endpackage

// File: rtl/wdm_align.sv
module wdm_align #(
   parameter int DATA_W = 12
) (
   input  logic [DATA_W-1:0] raw_i,
   input  logic [1:0]        res_i,
   output logic [DATA_W-1:0] left_o
);
   import wdm_pkg::*;

   // shifting out the top bits drops whatever sits above the resolution
   always_comb begin
      case (res_code_e'(res_i))
         RES_FULL:  left_o = raw_i;
         RES_LESS2: left_o = raw_i << 2;
         RES_LESS4: left_o = raw_i << 4;
         default:   left_o = raw_i << 6;
      endcase
   end
endmodule

// File: rtl/wdm_cfg.sv
module wdm_cfg #(
   parameter int CH_W        = 5,
   parameter int DATA_W      = 12,
   parameter int NUM_MASK_WD = 2,
   parameter int ADDR_W      = 3,
   parameter int REG_W       = 32
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                reg_we_i,
   input  logic [ADDR_W-1:0]                   reg_addr_i,
   input  logic [REG_W-1:0]                    reg_wdata_i,
   output logic [REG_W-1:0]                    reg_rdata_o,
   input  logic [NUM_MASK_WD:0]                flags_i,
   output logic [NUM_MASK_WD:0][(1<<CH_W)-1:0] guard_o,
   output logic [NUM_MASK_WD:0][DATA_W-1:0]    lo_o,
   output logic [NUM_MASK_WD:0][DATA_W-1:0]    hi_o,
   output logic [NUM_MASK_WD:0]                ien_o,
   output logic [NUM_MASK_WD:0]                clr_o
);
   import wdm_pkg::*;

   localparam int NUM_CH   = 1 << CH_W;
   localparam int NUM_WD   = NUM_MASK_WD + 1;
   localparam int A_STAT   = 2 * NUM_WD;
   localparam int A_IEN    = A_STAT + 1;
   localparam int NUM_REGS = A_IEN + 1;
   localparam int NUM_ADDR = 1 << ADDR_W;
   localparam int HI_LSB   = REG_W / 2;

   logic [REG_W-1:0] rd_word [NUM_ADDR];
   logic [NUM_WD-1:0] ien_q;

   for (genvar w = 0; w < NUM_WD; w++) begin : g_wd
      localparam int A_SEL = 2 * w;
      localparam int A_THR = 2 * w + 1;
      logic [DATA_W-1:0] lo_r, hi_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_r <= '0;
            hi_r <= '1;
         end else if (reg_we_i && reg_addr_i == ADDR_W'(A_THR)) begin
            lo_r <= reg_wdata_i[DATA_W-1:0];
            hi_r <= reg_wdata_i[HI_LSB +: DATA_W];
         end
      end
      assign lo_o[w] = lo_r;
      assign hi_o[w] = hi_r;
      assign rd_word[A_THR] = {{(REG_W-HI_LSB-DATA_W){1'b0}}, hi_r,
                               {(HI_LSB-DATA_W){1'b0}}, lo_r};

      if (w == 0) begin : g_all_or_one
         logic            en_r, single_r;
         logic [CH_W-1:0] ch_r;
         logic [NUM_CH-1:0] sel;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_r     <= 1'b0;
               single_r <= 1'b0;
               ch_r     <= '0;
            end else if (reg_we_i && reg_addr_i == ADDR_W'(A_SEL)) begin
               en_r     <= reg_wdata_i[CTRL_EN_BIT];
               single_r <= reg_wdata_i[CTRL_SINGLE_BIT];
               ch_r     <= reg_wdata_i[CTRL_CH_LSB +: CH_W];
            end
         end

         always_comb begin
            sel = '0;
            if (en_r) begin
               if (single_r) sel[ch_r] = 1'b1;
               else          sel = '1;
            end
         end
         assign guard_o[w] = sel;
         assign rd_word[A_SEL] = REG_W'({ch_r, 2'b00, single_r, en_r});
      end else begin : g_mask
         logic [NUM_CH-1:0] mask_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mask_r <= '0;
            else if (reg_we_i && reg_addr_i == ADDR_W'(A_SEL))
               mask_r <= reg_wdata_i[NUM_CH-1:0];
         end
         assign guard_o[w] = mask_r;
         assign rd_word[A_SEL] = REG_W'(mask_r);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ien_q <= '0;
      else if (reg_we_i && reg_addr_i == ADDR_W'(A_IEN))
         ien_q <= reg_wdata_i[NUM_WD-1:0];
   end

   assign rd_word[A_STAT] = REG_W'(flags_i);
   assign rd_word[A_IEN]  = REG_W'(ien_q);
   for (genvar a = NUM_REGS; a < NUM_ADDR; a++) begin : g_spare
      assign rd_word[a] = '0;
   end

   assign reg_rdata_o = rd_word[reg_addr_i];
   assign ien_o       = ien_q;
   assign clr_o       = (reg_we_i && reg_addr_i == ADDR_W'(A_STAT))
                        ? reg_wdata_i[NUM_WD-1:0] : '0;
endmodule

// File: rtl/wdm_unit.sv
module wdm_unit #(
   parameter int DATA_W = 12,
   parameter int CH_W   = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_valid_i,
   input  logic [CH_W-1:0]        smp_chan_i,
   input  logic [DATA_W-1:0]      smp_left_i,
   input  logic [(1<<CH_W)-1:0]   guard_i,
   input  logic [DATA_W-1:0]      thr_lo_i,
   input  logic [DATA_W-1:0]      thr_hi_i,
   input  logic                   clr_i,
   output logic                   flag_o
);
   logic guarded, below, above, hit, flag_q;

   assign guarded = guard_i[smp_chan_i];
   assign below   = smp_left_i < thr_lo_i;
   assign above   = smp_left_i > thr_hi_i;
   assign hit     = smp_valid_i && guarded && (below || above);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= hit | (flag_q & ~clr_i);
   end
   assign flag_o = flag_q;

   // R5: a flag only rises after a sample outside the window
   p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(smp_valid_i && (smp_left_i < thr_lo_i || smp_left_i > thr_hi_i)));
   // R5: samples on or between the thresholds never raise a flag
   p_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid_i && smp_left_i >= thr_lo_i && smp_left_i <= thr_hi_i && !flag_q) |=> !flag_q);
   // R4 (also R1, R3): an unguarded channel never raises a flag
   p_unguarded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid_i && !guard_i[smp_chan_i] && !flag_q) |=> !flag_q);
   // R7: a clear with no new violation drops the flag
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(smp_valid_i && guard_i[smp_chan_i] && (below || above))) |=> !flag_q);
   // R8: a violation beats a simultaneous clear
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && smp_valid_i && guard_i[smp_chan_i] && (below || above)) |=> flag_q);
   // R9: without a clear the flag persists
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/thr_watchdog_monitor.sv
module thr_watchdog_monitor #(
   parameter int CH_W        = 5,
   parameter int DATA_W      = 12,
   parameter int NUM_MASK_WD = 2,
   parameter int ADDR_W      = 3,
   parameter int REG_W       = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_valid,
   input  logic [CH_W-1:0]        smp_chan,
   input  logic [1:0]             smp_res,
   input  logic [DATA_W-1:0]      smp_data,
   input  logic                   reg_we,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [REG_W-1:0]       reg_wdata,
   output logic [REG_W-1:0]       reg_rdata,
   output logic                   irq,
   output logic [NUM_MASK_WD:0]   wd_out
);
   localparam int NUM_CH = 1 << CH_W;
   localparam int NUM_WD = NUM_MASK_WD + 1;

   if (NUM_CH > REG_W) begin : g_bad_mask_width
      $error("channel mask does not fit a register word");
   end
   if (2 * NUM_WD + 2 > (1 << ADDR_W)) begin : g_bad_addr_width
      $error("address width too small for the register set");
   end
   if (DATA_W >= REG_W / 2 || DATA_W < 7) begin : g_bad_data_width
      $error("sample width must be 7 or more and under half a register word");
   end
   if (CH_W + 4 > REG_W) begin : g_bad_chan_width
      $error("channel field does not fit the control word");
   end

   logic [DATA_W-1:0]               smp_left;
   logic [NUM_WD-1:0][NUM_CH-1:0]   guard;
   logic [NUM_WD-1:0][DATA_W-1:0]   thr_lo, thr_hi;
   logic [NUM_WD-1:0]               ien, clr, flags;

   wdm_align #(.DATA_W(DATA_W)) i_align (
      .raw_i  (smp_data),
      .res_i  (smp_res),
      .left_o (smp_left)
   );

   wdm_cfg #(
      .CH_W(CH_W), .DATA_W(DATA_W), .NUM_MASK_WD(NUM_MASK_WD),
      .ADDR_W(ADDR_W), .REG_W(REG_W)
   ) i_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_we_i    (reg_we),
      .reg_addr_i  (reg_addr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .flags_i     (flags),
      .guard_o     (guard),
      .lo_o        (thr_lo),
      .hi_o        (thr_hi),
      .ien_o       (ien),
      .clr_o       (clr)
   );

   for (genvar w = 0; w < NUM_WD; w++) begin : g_unit
      wdm_unit #(.DATA_W(DATA_W), .CH_W(CH_W)) i_unit (
         .clk         (clk),
         .rst_n       (rst_n),
         .smp_valid_i (smp_valid),
         .smp_chan_i  (smp_chan),
         .smp_left_i  (smp_left),
         .guard_i     (guard[w]),
         .thr_lo_i    (thr_lo[w]),
         .thr_hi_i    (thr_hi[w]),
         .clr_i       (clr[w]),
         .flag_o      (flags[w])
      );
   end

   assign wd_out = flags;
   assign irq    = |(flags & ien);

   // R11: a hardware line can only rise one cycle after a sample
   p_out_after_sample_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|wd_out) |-> $past(smp_valid));
   // R10: the interrupt never shows without a raised line
   p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (wd_out != '0));
endmodule

// File: tb/test_thr_watchdog_monitor.sv
`timescale 1ns/1ps
module test_thr_watchdog_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [4:0]  smp_chan = '0;
   logic [1:0]  smp_res = '0;
   logic [11:0] smp_data = '0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic [2:0]  wd_out;

   int nvec = 0;
   int nerr = 0;
   int cycles = 0;
   string cur_req = "R12";

   always #2 clk = ~clk;

   thr_watchdog_monitor i_thr_watchdog_monitor (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
      .smp_res(smp_res), .smp_data(smp_data), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .wd_out(wd_out)
   );

   // ---------------- behavioural reference model ----------------
   logic        m_en, m_single;
   logic [4:0]  m_ch;
   logic [11:0] m_lo [3];
   logic [11:0] m_hi [3];
   logic [31:0] m_mask [3];
   logic [2:0]  m_ien, m_flag;

   function automatic logic [11:0] m_left(logic [1:0] r, logic [11:0] d);
      case (r)
         2'd0: return d;
         2'd1: return {d[9:0], 2'b00};
         2'd2: return {d[7:0], 4'h0};
         default: return {d[5:0], 6'h00};
      endcase
   endfunction

   function automatic bit m_guards(int w, logic [4:0] ch);
      if (w == 0) return m_en && (!m_single || ch == m_ch);
      return m_mask[w][ch];
   endfunction

   function automatic logic [31:0] m_read(int a);
      case (a)
         0: return {23'd0, m_ch, 2'b00, m_single, m_en};
         1, 3, 5: return {4'h0, m_hi[(a-1)/2], 4'h0, m_lo[(a-1)/2]};
         2, 4: return m_mask[a/2];
         6: return {29'd0, m_flag};
         default: return {29'd0, m_ien};
      endcase
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s (scenario %s) %s: actual %h expected %h", req, cur_req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      logic [2:0] nf;
      logic [11:0] l;
      if (!rst_n) begin
         m_en = 0; m_single = 0; m_ch = '0; m_ien = '0; m_flag = '0;
         for (int w = 0; w < 3; w++) begin
            m_lo[w] = 12'h000; m_hi[w] = 12'hFFF; m_mask[w] = '0;
         end
      end else begin
         nf = m_flag;
         if (reg_we && reg_addr == 3'd6) nf = nf & ~reg_wdata[2:0];
         if (smp_valid) begin
            l = m_left(smp_res, smp_data);
            for (int w = 0; w < 3; w++)
               if (m_guards(w, smp_chan) && (l < m_lo[w] || l > m_hi[w])) nf[w] = 1'b1;
         end
         if (reg_we) begin
            case (reg_addr)
               3'd0: begin m_en = reg_wdata[0]; m_single = reg_wdata[1]; m_ch = reg_wdata[8:4]; end
               3'd1, 3'd3, 3'd5: begin
                  m_lo[reg_addr/2] = reg_wdata[11:0];
                  m_hi[reg_addr/2] = reg_wdata[27:16];
               end
               3'd2, 3'd4: m_mask[reg_addr/2] = reg_wdata;
               3'd7: m_ien = reg_wdata[2:0];
               default: ;
            endcase
         end
         m_flag = nf;
      end
      #1;
      chk("R11", "wd_out", 32'(wd_out), 32'(m_flag));
      chk("R10", "irq", 32'(irq), 32'(|(m_flag & m_ien)));
      chk("R13", "reg_rdata", reg_rdata, m_read(int'(reg_addr)));
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cycles++;
      if (cycles > 60000) begin
         nerr++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive(bit we, int a, logic [31:0] wd, bit v, int ch, int r, logic [11:0] d);
      @(negedge clk);
      reg_we = we; reg_addr = 3'(a); reg_wdata = wd;
      smp_valid = v; smp_chan = 5'(ch); smp_res = 2'(r); smp_data = d;
   endtask
   task automatic wr(int a, logic [31:0] wd);
      drive(1, a, wd, 0, 0, 0, 12'h0);
   endtask
   task automatic smp(int ch, int r, logic [11:0] d);
      drive(0, 6, 32'h0, 1, ch, r, d);
   endtask
   task automatic idle(int n);
      repeat (n) drive(0, 6, 32'h0, 0, 0, 0, 12'h0);
   endtask
   function automatic logic [31:0] thr(logic [11:0] hi, logic [11:0] lo);
      return {4'h0, hi, 4'h0, lo};
   endfunction

   initial begin
      // R12: reset contents, read at every address
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int a = 0; a < 8; a++) drive(0, a, 32'h0, 0, 0, 0, 12'h0);

      // R13: readback of written words (also covers field positions)
      cur_req = "R13";
      wr(0, 32'hFFFF_FE7C); drive(0, 0, 32'h0, 0, 0, 0, 12'h0);
      wr(0, 32'h0);
      wr(7, 32'hFFFF_FFF8); drive(0, 7, 32'h0, 0, 0, 0, 12'h0);

      // R1: disabled first watchdog ignores a far-out sample
      cur_req = "R1";
      wr(1, thr(12'h800, 12'h400));
      smp(3, 0, 12'hFFF); smp(3, 0, 12'h000); idle(2);

      // R2: all channels guarded
      cur_req = "R2";
      wr(0, 32'h1);
      smp(5, 0, 12'h100); idle(1); wr(6, 32'h1); idle(1);
      smp(31, 0, 12'h900); idle(1); wr(6, 32'h1); idle(1);

      // R3: single channel 7 only
      cur_req = "R3";
      wr(0, 32'h73);
      smp(8, 0, 12'hFFF); idle(1);
      smp(7, 0, 12'h000); idle(1); wr(6, 32'h1); idle(1);

      // R5: exact thresholds are inside, one step out is outside
      cur_req = "R5";
      smp(7, 0, 12'h400); smp(7, 0, 12'h800); idle(1);
      smp(7, 0, 12'h3FF); idle(1); wr(6, 32'h1);
      smp(7, 0, 12'h801); idle(1); wr(6, 32'h1); idle(1);

      // R6: alignment at each resolution
      cur_req = "R6";
      smp(7, 1, 12'h0FF); idle(1); wr(6, 32'h1);
      smp(7, 1, 12'h100); idle(1);
      smp(7, 2, 12'h020); idle(1); wr(6, 32'h1);
      smp(7, 3, 12'h03F); idle(1); wr(6, 32'h1);
      smp(7, 3, 12'hF10); idle(2);

      // R4: mask-selected watchdogs, zero mask disabled
      cur_req = "R4";
      wr(3, thr(12'hA00, 12'h200)); wr(5, thr(12'hA00, 12'h200));
      wr(2, (32'h1 << 2) | (32'h1 << 9));
      smp(2, 0, 12'hB00); idle(1);
      smp(4, 0, 12'hFFF); idle(1);
      wr(4, 32'h1 << 4);
      smp(4, 0, 12'hFFF); smp(9, 0, 12'h100); idle(1);

      // R7: writing 0 keeps flags, writing 1 clears only the chosen one
      cur_req = "R7";
      wr(6, 32'h0); idle(1);
      wr(6, 32'h4); idle(1);
      wr(6, 32'h2); idle(1);

      // R8: set wins over a simultaneous clear
      cur_req = "R8";
      drive(1, 6, 32'h1, 1, 7, 0, 12'hFFF); idle(1);
      drive(1, 6, 32'h3, 1, 2, 0, 12'hFFF); idle(1);
      wr(6, 32'h7); idle(1);

      // R9, R10: sticky flags and interrupt masking
      cur_req = "R10";
      wr(7, 32'h5);
      smp(2, 0, 12'h000); idle(3);
      smp(7, 0, 12'hFFF); idle(3);
      wr(6, 32'h1); idle(1);
      wr(6, 32'h2); idle(1);

      // R11 and all others: long random mix
      cur_req = "random";
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 9);
         if (r < 2)
            drive(1, $urandom_range(0, 7), $urandom, 0, 0, 0, 12'h0);
         else if (r == 2)
            drive(1, 6, 32'($urandom_range(0, 7)), 1, $urandom_range(0, 31),
                  $urandom_range(0, 3), 12'($urandom));
         else
            drive(0, $urandom_range(0, 7), 32'h0, 1, $urandom_range(0, 31),
                  $urandom_range(0, 3), 12'($urandom));
      end
      idle(2);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule